// File: doc/BRIEF.md
# Montgomery Modular Arithmetic Unit

This block is a multi-cycle arithmetic engine for a prime field. It supports modular addition, subtraction, multiplication and inversion. Every operand and every result is in Montgomery form, with R = 2^W. The caller presents two operands and an odd prime modulus, chooses an operation code and pulses `start`. The unit captures all of these at the edge that accepts the strobe. It then runs the operation on one shared datapath and pulses `done` for one cycle, with `result` valid in that same cycle.

The shared datapath has three adder/subtractor units, a shift stage that moves values right or left, and four working registers. Multiplication is bit-serial and reduces one multiplier bit per cycle. Inversion runs in two phases. The first is a binary almost-inverse loop that yields a^-1·2^k mod p, where k is the loop count. The second applies 2W−k modular doublings, which leaves the answer already in Montgomery form. Operands must be below the modulus. The modulus must be an odd prime below 2^W.

Top module: `mont_arith_unit`

## Requirements
- R1: With op = 2'b00 the result is (a + b) mod p, and `done` rises exactly two clock edges after the edge that accepts `start`.
- R2: With op = 2'b01 the result is (a − b) mod p, with the same two-edge latency as R1.
- R3: With op = 2'b10 the result is a·b·2^−W mod p, and `done` rises exactly W+2 edges after the accepting edge.
- R4: With op = 2'b11 and a ≠ 0 the result is 2^(2W)·a^−1 mod p, which is the Montgomery form of the inverse, and `err` stays low.
- R5: With op = 2'b11 and a = 0 the result is 0 and `err` is high in the `done` cycle.
- R6: `done` is high for exactly one cycle per operation, and `err` is never high outside a `done` cycle.
- R7: Every result is fully reduced, that is, strictly below p.
- R8: A `start` pulse while `busy` is high is ignored. The operation in flight keeps the operands, the modulus and the code it captured.
- R9: After reset, `busy`, `done` and `err` are low and `result` is 0.
- R10: The almost-inverse loop runs at most 2W iterations.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begins an operation when the unit is idle |
| op | input | 2 | Operation code: 00 add, 01 subtract, 10 multiply, 11 invert |
| opnd_a | input | W | First operand, Montgomery form, below p |
| opnd_b | input | W | Second operand, Montgomery form, below p (unused by invert) |
| modulus | input | W | Odd prime modulus p |
| busy | output | 1 | High while an operation is in progress |
| done | output | 1 | One-cycle pulse marking a valid result |
| err | output | 1 | High with `done` when zero was inverted |
| result | output | W | Result of the last operation |

## Verification
On every cycle, the assertions check the following: the fixed two-edge latency of add and subtract, the single-cycle `done` pulse, that `err` only appears with `done`, that stored results stay below the captured modulus, that the captured modulus and code hold while busy, and the 2W bound on the inversion loop. Only the bench scenarios can show that the values themselves are right. Those cover modular sums, differences, Montgomery products and inverses across full and strided operand sweeps under three moduli, plus the zero-inverse case and a strobe fired into a busy unit.

// File: rtl/mau_pkg.sv
`timescale 1ns/1ps
package mau_pkg;
   typedef enum logic [1:0] {
      OP_ADD = 2'd0,
      OP_SUB = 2'd1,
      OP_MUL = 2'd2,
      OP_INV = 2'd3
   } mau_op_e;

   typedef enum logic [3:0] {
      ST_IDLE,
      ST_ADSB_FIX,
      ST_MUL_STEP,
      ST_MUL_FIX,
      ST_INV_ZERO,
      ST_INV_LOOP,
      ST_INV_RED,
      ST_INV_NEG,
      ST_INV_DBL
   } mau_state_e;
endpackage

// File: rtl/mau_addsub.sv
`timescale 1ns/1ps
// N-bit adder/subtractor; s[N] is carry for add, borrow for subtract.
module mau_addsub #(
   parameter int N = 10,
   parameter bit SUB_BY_COMPLEMENT = 1'b1
) (
   input  logic [N-1:0] x,
   input  logic [N-1:0] y,
   input  logic         sub,
   output logic [N:0]   s
);
   generate
      if (SUB_BY_COMPLEMENT) begin : g_cmpl
         logic [N:0] t;
         assign t = {1'b0, x} + {1'b0, (sub ? ~y : y)} + {{N{1'b0}}, sub};
         assign s = {t[N] ^ sub, t[N-1:0]};
      end else begin : g_direct
         assign s = sub ? ({1'b0, x} - {1'b0, y}) : ({1'b0, x} + {1'b0, y});
      end
   endgenerate
endmodule

// File: rtl/mau_ctrl.sv
`timescale 1ns/1ps
module mau_ctrl import mau_pkg::*; #(
   parameter int W = 8,
   localparam int CW = $clog2(2*W+1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  mau_op_e          op,
   input  logic             a_zero,
   input  logic             v_zero,
   output mau_state_e       state,
   output mau_op_e          op_q,
   output logic [CW-1:0]    cnt,
   output logic             res_we,
   output logic             busy,
   output logic             done,
   output logic             err
);
   localparam logic [CW-1:0] MUL_LAST = CW'(W-1);
   localparam logic [CW-1:0] CNT_TOP  = CW'(2*W);

   assign busy   = (state != ST_IDLE);
   assign res_we = (state == ST_ADSB_FIX) || (state == ST_MUL_FIX) ||
                   (state == ST_INV_ZERO) ||
                   ((state == ST_INV_DBL) && (cnt == CNT_TOP));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= ST_IDLE;
         op_q  <= OP_ADD;
         cnt   <= '0;
         done  <= 1'b0;
         err   <= 1'b0;
      end else begin
         done <= res_we;
         err  <= (state == ST_INV_ZERO);
         case (state)
            ST_IDLE: if (start) begin
               op_q <= op;
               cnt  <= '0;
               case (op)
                  OP_ADD, OP_SUB: state <= ST_ADSB_FIX;
                  OP_MUL:         state <= ST_MUL_STEP;
                  default:        state <= a_zero ? ST_INV_ZERO : ST_INV_LOOP;
               endcase
            end
            ST_ADSB_FIX, ST_MUL_FIX, ST_INV_ZERO: state <= ST_IDLE;
            ST_MUL_STEP: begin
               cnt <= cnt + 1'b1;
               if (cnt == MUL_LAST) state <= ST_MUL_FIX;
            end
            ST_INV_LOOP: if (v_zero) state <= ST_INV_RED;
                         else        cnt   <= cnt + 1'b1;
            ST_INV_RED: state <= ST_INV_NEG;
            ST_INV_NEG: state <= ST_INV_DBL;
            ST_INV_DBL: if (cnt == CNT_TOP) state <= ST_IDLE;
                        else                cnt   <= cnt + 1'b1;
            default: state <= ST_IDLE;
         endcase
      end
   end

   // R1 and R2: add/subtract complete two edges after acceptance
   a_r1_addsub_latency: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_IDLE && start && (op == OP_ADD || op == OP_SUB)) |-> ##2 done);
   a_r6_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   a_r6_err_with_done: assert property (@(posedge clk) disable iff (!rst_n)
      err |-> done);
   a_r8_code_held: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && start) |=> $stable(op_q));
   a_r10_loop_bound: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_INV_LOOP && !v_zero) |-> (cnt < CNT_TOP));
endmodule

// File: rtl/mau_dp.sv
`timescale 1ns/1ps
module mau_dp import mau_pkg::*; #(
   parameter int W = 8,
   parameter bit SUB_BY_COMPLEMENT = 1'b1,
   localparam int CW = $clog2(2*W+1),
   localparam int E  = W + 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  mau_op_e       op,
   input  logic [W-1:0]  a_in,
   input  logic [W-1:0]  b_in,
   input  logic [W-1:0]  mod_in,
   input  mau_state_e    state,
   input  mau_op_e       op_q,
   input  logic [CW-1:0] cnt,
   input  logic          res_we,
   output logic          a_zero,
   output logic          v_zero,
   output logic [W-1:0]  res
);
   localparam logic [CW-1:0] CNT_TOP = CW'(2*W);

   logic [E-1:0] ru, rv, rr, rs;
   logic [W-1:0] rp;
   logic [E-1:0] pe;
   logic [E-1:0] x0, y0, x1, y1, x2, y2;
   logic         b0, b1, b2;
   logic [E:0]   s0, s1, s2;

   assign pe     = {2'b00, rp};
   assign a_zero = (a_in == '0);
   assign v_zero = (rv == '0);

   mau_addsub #(.N(E), .SUB_BY_COMPLEMENT(SUB_BY_COMPLEMENT)) u_as0 (.x(x0), .y(y0), .sub(b0), .s(s0));
   mau_addsub #(.N(E), .SUB_BY_COMPLEMENT(SUB_BY_COMPLEMENT)) u_as1 (.x(x1), .y(y1), .sub(b1), .s(s1));
   mau_addsub #(.N(E), .SUB_BY_COMPLEMENT(SUB_BY_COMPLEMENT)) u_as2 (.x(x2), .y(y2), .sub(b2), .s(s2));

   // unit 0: first stage of every operation
   always_comb begin
      x0 = '0; y0 = '0; b0 = 1'b0;
      case (state)
         ST_IDLE:     begin x0 = {2'b00, a_in}; y0 = {2'b00, b_in}; b0 = (op == OP_SUB); end
         ST_ADSB_FIX: begin x0 = ru; y0 = pe; b0 = (op_q == OP_ADD); end
         ST_MUL_STEP: begin x0 = ru; y0 = rs[0] ? rv : '0; end
         ST_MUL_FIX:  begin x0 = ru; y0 = pe; b0 = 1'b1; end
         ST_INV_LOOP: begin x0 = ru; y0 = rv; b0 = 1'b1; end
         ST_INV_RED:  begin x0 = rr; y0 = pe; b0 = 1'b1; end
         ST_INV_NEG:  begin x0 = pe; y0 = rr; b0 = 1'b1; end
         ST_INV_DBL:  begin x0 = rr; y0 = rr; end
         default: ;
      endcase
   end

   // unit 1: chained after unit 0 (odd fix-up, trial reduction) or v-u
   always_comb begin
      x1 = '0; y1 = '0; b1 = 1'b0;
      case (state)
         ST_MUL_STEP: begin x1 = s0[E-1:0]; y1 = s0[0] ? pe : '0; end
         ST_INV_LOOP: begin x1 = rv; y1 = ru; b1 = 1'b1; end
         ST_INV_DBL:  begin x1 = s0[E-1:0]; y1 = pe; b1 = 1'b1; end
         default: ;
      endcase
   end

   // unit 2: coefficient sum in the almost-inverse loop
   always_comb begin
      x2 = rr; y2 = rs; b2 = 1'b0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ru <= '0; rv <= '0; rr <= '0; rs <= '0; rp <= '0; res <= '0;
      end else begin
         case (state)
            ST_IDLE: if (start) begin
               rp <= mod_in;
               rv <= {2'b00, a_in};
               rr <= '0;
               case (op)
                  OP_ADD, OP_SUB: begin ru <= s0[E-1:0]; rs <= '0; end
                  OP_MUL:         begin ru <= '0; rs <= {2'b00, b_in}; end
                  default:        begin ru <= {2'b00, mod_in}; rs <= E'(1); end
               endcase
            end
            ST_ADSB_FIX:
               if (op_q == OP_ADD) res <= s0[E] ? ru[W-1:0] : s0[W-1:0];
               else                res <= ru[E-1] ? s0[W-1:0] : ru[W-1:0];
            ST_MUL_STEP: begin
               ru <= s1[E:1];
               rs <= rs >> 1;
            end
            ST_MUL_FIX:  res <= s0[E] ? ru[W-1:0] : s0[W-1:0];
            ST_INV_ZERO: res <= '0;
            ST_INV_LOOP: if (!v_zero) begin
               if (!ru[0]) begin
                  ru <= ru >> 1;
                  rs <= {rs[E-2:0], 1'b0};
               end else if (!rv[0]) begin
                  rv <= rv >> 1;
                  rr <= {rr[E-2:0], 1'b0};
               end else if (s1[E]) begin
                  ru <= s0[E:1];
                  rr <= s2[E-1:0];
                  rs <= {rs[E-2:0], 1'b0};
               end else begin
                  rv <= s1[E:1];
                  rs <= s2[E-1:0];
                  rr <= {rr[E-2:0], 1'b0};
               end
            end
            ST_INV_RED: if (!s0[E]) rr <= s0[E-1:0];
            ST_INV_NEG: rr <= s0[E-1:0];
            ST_INV_DBL:
               if (cnt == CNT_TOP) res <= rr[W-1:0];
               else                rr  <= s1[E] ? s0[E-1:0] : s1[E-1:0];
            default: ;
         endcase
      end
   end

   logic sink_unused;
   assign sink_unused = ^{s1[0], s2[E]};

   a_r7_result_reduced: assert property (@(posedge clk) disable iff (!rst_n)
      res_we |=> (res < rp));
   a_r8_modulus_held: assert property (@(posedge clk) disable iff (!rst_n)
      (state != ST_IDLE) |=> $stable(rp));
endmodule

// File: rtl/mont_arith_unit.sv
`timescale 1ns/1ps
module mont_arith_unit import mau_pkg::*; #(
   parameter int W = 8,
   parameter bit SUB_BY_COMPLEMENT = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         start,
   input  logic [1:0]   op,
   input  logic [W-1:0] opnd_a,
   input  logic [W-1:0] opnd_b,
   input  logic [W-1:0] modulus,
   output logic         busy,
   output logic         done,
   output logic         err,
   output logic [W-1:0] result
);
   localparam int CW = $clog2(2*W+1);

   generate
      if (W < 3) begin : g_bad_width
         $error("mont_arith_unit: W must be at least 3");
      end
   endgenerate

   mau_op_e       op_e, op_q;
   mau_state_e    state;
   logic [CW-1:0] cnt;
   logic          res_we, a_zero, v_zero;

   assign op_e = mau_op_e'(op);

   mau_ctrl #(.W(W)) u_ctrl (
      .clk(clk), .rst_n(rst_n), .start(start), .op(op_e),
      .a_zero(a_zero), .v_zero(v_zero), .state(state), .op_q(op_q),
      .cnt(cnt), .res_we(res_we), .busy(busy), .done(done), .err(err)
   );

   mau_dp #(.W(W), .SUB_BY_COMPLEMENT(SUB_BY_COMPLEMENT)) u_dp (
      .clk(clk), .rst_n(rst_n), .start(start), .op(op_e),
      .a_in(opnd_a), .b_in(opnd_b), .mod_in(modulus),
      .state(state), .op_q(op_q), .cnt(cnt), .res_we(res_we),
      .a_zero(a_zero), .v_zero(v_zero), .res(result)
   );
endmodule

// File: tb/sim_mont_arith_unit.sv
`timescale 1ns/1ps
module sim_mont_arith_unit;
   localparam int W = 8;
   localparam int RV = 1 << W;

   logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
   logic [1:0] op = 2'd0;
   logic [W-1:0] a = '0, b = '0, m = '0;
   logic busy, done, err;
   logic [W-1:0] result;
   int n_cmp = 0, n_bad = 0, cyc = 0;

   mont_arith_unit #(.W(W)) u0 (
      .clk(clk), .rst_n(rst_n), .start(start), .op(op),
      .opnd_a(a), .opnd_b(b), .modulus(m),
      .busy(busy), .done(done), .err(err), .result(result)
   );

   always #2.5 clk = ~clk;

   always @(posedge clk) begin
      cyc++;
      if (cyc == 150000) begin
         n_bad++;
         $display("FAIL watchdog: ran %0d cycles, expected fewer than 150000", cyc);
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   task automatic check(input string tag, input int act, input int exp);
      n_cmp++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   function automatic int minv(input int x, input int p);
      for (int y = 1; y < p; y++) if ((x * y) % p == 1) return y;
      return 0;
   endfunction

   task automatic run_op(input int o, input int x, input int y, input int p,
                         output int res, output int e, output int lat);
      @(negedge clk);
      op = 2'(o); a = W'(x); b = W'(y); m = W'(p); start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      lat = 1;
      while (!done && lat < 400) begin
         @(negedge clk);
         lat++;
      end
      res = int'(result);
      e = int'(err);
   endtask

   task automatic sweep(input int p);
      int res, e, lat, stx, sty, rinv, r2;
      stx = (p > 20) ? 5 : 1;
      sty = (p > 20) ? 7 : 1;
      rinv = minv(RV % p, p);
      r2 = ((RV % p) * (RV % p)) % p;
      for (int x = 0; x < p; x += stx) begin
         for (int y = 0; y < p; y += sty) begin
            run_op(0, x, y, p, res, e, lat);
            check("R1 add value", res, (x + y) % p);
            check("R1 add latency", lat, 2);
            run_op(1, x, y, p, res, e, lat);
            check("R2 sub value", res, (x - y + p) % p);
            check("R2 sub latency", lat, 2);
            run_op(2, x, y, p, res, e, lat);
            check("R3 mul value", res, (((x * y) % p) * rinv) % p);
            check("R3 mul latency", lat, W + 2);
            if (res >= p) check("R7 reduced", res, p - 1);
         end
      end
      for (int x = 1; x < p; x++) begin
         run_op(3, x, 0, p, res, e, lat);
         check("R4 inv value", res, (r2 * minv(x, p)) % p);
         check("R4 inv err low", e, 0);
      end
      run_op(3, 0, 0, p, res, e, lat);
      check("R5 zero inverse value", res, 0);
      check("R5 zero inverse err", e, 1);
   endtask

   initial begin
      int res, e, lat, extra;
      repeat (3) @(negedge clk);
      check("R9 reset busy", int'(busy), 0);
      check("R9 reset done", int'(done), 0);
      check("R9 reset err", int'(err), 0);
      check("R9 reset result", int'(result), 0);
      rst_n = 1'b1;
      @(negedge clk);

      sweep(3);
      sweep(13);
      sweep(251);

      // R8: strobe into a busy unit; R6: single done pulse
      @(negedge clk);
      op = 2'd2; a = W'(7); b = W'(9); m = W'(13); start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      @(negedge clk);
      op = 2'd0; a = W'(1); b = W'(1); m = W'(11); start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      lat = 0;
      while (!done && lat < 100) begin
         @(negedge clk);
         lat++;
      end
      check("R8 busy strobe ignored", int'(result), ((63 % 13) * minv(RV % 13, 13)) % 13);
      extra = 0;
      for (int i = 0; i < 2 * W; i++) begin
         @(negedge clk);
         if (done) extra++;
      end
      check("R6 single done pulse", extra, 0);

      run_op(1, 2, 9, 11, res, e, lat);
      check("R6 err low on sub", e, 0);
      check("R2 sub wraps", res, 4);

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule